// File: doc/BRIEF.md
# Multi-Port RAM with Invalidation-Coded Bank Table

This block is a memory with `NW` write ports and `NR` read ports. It is built only from simple arrays that have one write port and one read port each. Every write port owns its own data bank, and that bank is copied once for each read port. A read port can therefore fetch the newest word from every writer in the same cycle. A small table records, for each address, which writer holds the live word. Each read port uses that table to steer its output multiplexer.

The table is built from the same kind of arrays. Each write port has its own table bank, and those banks are replicated. A write never modifies the entries of other writers. Instead, the writer stores a code that, when combined by XOR with what the other banks already hold at that address, produces its own identity. This cancels out the earlier claims at that address. The `ONEHOT` parameter selects the coding. With `ONEHOT=0`, each entry is a binary port index. With `ONEHOT=1`, each entry is `NW` bits wide and the combined value is a one-hot select.

Reads take one clock cycle. The block is used wherever several agents need parallel access to one shared store, such as the lanes of a wide datapath.

Top module: `mpram_ilvt`

## Requirements
- R1: A word written by any write port on cycle t is returned by every read port whose address equals that address on cycle t+1 or later, until the address is written again.
- R2: Read data appears one clock edge after the read address is presented: `rd_data` slice r, sampled after edge k, reflects `rd_addr` slice r as presented before edge k.
- R3: A read presented on the same cycle as a write to the same address returns the value held before that write.
- R4: When different write ports write one address on different cycles, reads return the word of the most recent writer.
- R5: All write ports may write distinct addresses in the same cycle, and every one of those words is stored.
- R6: Read ports are independent, and read ports that present the same address on one cycle return identical data.
- R7: With `ONEHOT=0`, the XOR of the `NW` binary table entries at a written address equals the index of the last write port (0 to NW-1), and that bank drives the output.
- R8: With `ONEHOT=1`, the bitwise XOR of the `NW` table entries at any address has at most one bit set, and bit w is set exactly when port w wrote the address last.
- R9: If a read port keeps the same address and no write occurs on the cycle before, its output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and read-address captures occur on its rising edge |
| wr_en | input | NW | Write enable, bit w for write port w |
| wr_addr | input | NW*AW | Write addresses, slice w belongs to port w |
| wr_data | input | NW*DW | Write data, slice w belongs to port w |
| rd_addr | input | NR*AW | Read addresses, slice r belongs to read port r |
| rd_data | output | NR*DW | Read data, slice r belongs to read port r, one cycle after its address |

## Verification
A corrupted table entry does not stall the block and does not cause an X. It appears as a plausible but wrong word: the output of a stale writer's bank, or, in one-hot coding, a select with zero bits or two bits set. The bench compares every read port against a behavioural model on every cycle. A wrong update is therefore reported one cycle after the first read of the damaged address. Overwrites of one address by different ports are repeated on purpose, because a wrong cancellation term is only visible after two or more writers have touched the same word.

// File: rtl/mpram_sdp_array.sv
module mpram_sdp_array #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter bit REG_RD = 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk)
    if (we) mem[wa] <= wd;

  generate
    if (REG_RD) begin : g_sync
      always_ff @(posedge clk) rd <= mem[ra];
    end else begin : g_comb
      assign rd = mem[ra];
    end
  endgenerate
endmodule

// File: rtl/mpram_ilvt.sv
module mpram_ilvt #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int DW = 16,
  parameter int DEPTH = 64,
  parameter bit ONEHOT = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int EW = ONEHOT ? NW : IW
) (
  input  logic               clk,
  input  logic [NW-1:0]      wr_en,
  input  logic [NW*AW-1:0]   wr_addr,
  input  logic [NW*DW-1:0]   wr_data,
  input  logic [NR*AW-1:0]   rd_addr,
  output logic [NR*DW-1:0]   rd_data
);
  logic [DW-1:0] bank_q [NW][NR];
  logic [EW-1:0] tab_q  [NW][NR];
  logic [EW-1:0] peer   [NW][NW];
  logic [EW-1:0] tnew   [NW];
  logic [EW-1:0] rsel   [NR];
  logic [DW-1:0] rmux   [NR];

  genvar w, r, j;
  generate
    for (w = 0; w < NW; w++) begin : g_wr
      for (r = 0; r < NR; r++) begin : g_rd
        mpram_sdp_array #(.DW(DW), .AW(AW), .REG_RD(1)) u_data (
          .clk(clk), .we(wr_en[w]), .wa(wr_addr[w*AW +: AW]), .wd(wr_data[w*DW +: DW]),
          .ra(rd_addr[r*AW +: AW]), .rd(bank_q[w][r]));
        mpram_sdp_array #(.DW(EW), .AW(AW), .REG_RD(1)) u_tab (
          .clk(clk), .we(wr_en[w]), .wa(wr_addr[w*AW +: AW]), .wd(tnew[w]),
          .ra(rd_addr[r*AW +: AW]), .rd(tab_q[w][r]));
      end
      for (j = 0; j < NW; j++) begin : g_peer
        if (j == w) begin : g_self
          assign peer[w][j] = '0;
        end else begin : g_copy
          mpram_sdp_array #(.DW(EW), .AW(AW), .REG_RD(0)) u_ptab (
            .clk(clk), .we(wr_en[j]), .wa(wr_addr[j*AW +: AW]), .wd(tnew[j]),
            .ra(wr_addr[w*AW +: AW]), .rd(peer[w][j]));
        end
      end
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < NW; p++) begin
      logic [EW-1:0] acc, code;
      acc = '0;
      for (int q = 0; q < NW; q++) acc ^= peer[p][q];
      code = ONEHOT ? (EW'(1) << p) : EW'(p);
      tnew[p] = code ^ acc;
    end
  end

  always_comb begin
    for (int p = 0; p < NR; p++) begin
      logic [EW-1:0] s;
      s = '0;
      for (int q = 0; q < NW; q++) s ^= tab_q[q][p];
      rsel[p] = s;
      rmux[p] = '0;
      for (int q = 0; q < NW; q++) begin
        if (ONEHOT) begin
          if (s[q % EW]) rmux[p] |= bank_q[q][p];
        end else if (32'(s) == q) begin
          rmux[p] = bank_q[q][p];
        end
      end
    end
  end

  generate
    for (r = 0; r < NR; r++) begin : g_out
      assign rd_data[r*DW +: DW] = rmux[r];
    end
  endgenerate
endmodule

// File: rtl/mpram_ilvt_chk.sv
module mpram_ilvt_chk #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int EW = 1,
  parameter bit ONEHOT = 0
) (
  input logic             clk,
  input logic [NW-1:0]    wr_en,
  input logic [NW*AW-1:0] wr_addr,
  input logic [NW*DW-1:0] wr_data,
  input logic [NR*AW-1:0] rd_addr,
  input logic [NR*DW-1:0] rd_data,
  input logic [EW-1:0]    rsel [NR]
);
  logic [1:0] age = 2'd0;
  always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;

  // R1
  write_visible_chk: assert property (@(posedge clk) disable iff (age < 2'd1)
    (wr_en[0] ##1 (rd_addr[0 +: AW] == $past(wr_addr[0 +: AW])))
    |=> rd_data[0 +: DW] == $past(wr_data[0 +: DW], 2));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (age < 2'd2)
    (rd_addr[0 +: AW] == $past(rd_addr[0 +: AW]) && $past(wr_en) == '0)
    |=> $stable(rd_data[0 +: DW]));

  generate
    if (NR > 1) begin : g_pair
      // R6
      same_addr_chk: assert property (@(posedge clk) disable iff (age < 2'd1)
        (rd_addr[0 +: AW] == rd_addr[AW +: AW]) |=> rd_data[0 +: DW] == rd_data[DW +: DW]);
    end
    for (genvar r = 0; r < NR; r++) begin : g_sel
      if (ONEHOT) begin : g_oh
        // R8
        onehot_sel_chk: assert property (@(posedge clk) disable iff (age < 2'd2)
          $onehot0(rsel[r]));
      end else begin : g_bin
        // R7
        live_index_chk: assert property (@(posedge clk) disable iff (age < 2'd2)
          32'(rsel[r]) < NW);
      end
    end
  endgenerate
endmodule

bind mpram_ilvt mpram_ilvt_chk #(
  .NW(NW), .NR(NR), .DW(DW), .AW(AW), .EW(EW), .ONEHOT(ONEHOT)
) u_chk (
  .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .rsel(rsel)
);

// File: tb/test_mpram_ilvt.sv
module test_mpram_ilvt;
  localparam int NW = 3;
  localparam int NR = 3;
  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_bin, rd_oh;

  mpram_ilvt #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH), .ONEHOT(0)) i_mpram_ilvt (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_bin));
  mpram_ilvt #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH), .ONEHOT(1)) i_mpram_ilvt_oh (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_oh));

  logic [DW-1:0] gold [DEPTH];
  bit            known [DEPTH];
  int checks = 0;
  int fails = 0;

  task automatic put(input int w, input int a, input logic [DW-1:0] d);
    wr_en[w] = 1'b1;
    wr_addr[w*AW +: AW] = AW'(a);
    wr_data[w*DW +: DW] = d;
  endtask

  task automatic look(input int r, input int a);
    rd_addr[r*AW +: AW] = AW'(a);
  endtask

  task automatic step(input string tag);
    logic [DW-1:0] exp_d [NR];
    bit exp_v [NR];
    for (int r = 0; r < NR; r++) begin
      exp_v[r] = known[rd_addr[r*AW +: AW]];
      exp_d[r] = gold[rd_addr[r*AW +: AW]];
    end
    for (int w = 0; w < NW; w++)
      if (wr_en[w]) begin
        gold[wr_addr[w*AW +: AW]] = wr_data[w*DW +: DW];
        known[wr_addr[w*AW +: AW]] = 1'b1;
      end
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < NR; r++)
      if (exp_v[r]) begin
        checks += 2;
        if (rd_bin[r*DW +: DW] !== exp_d[r]) begin
          fails++;
          $display("FAIL %s R7 port %0d: got %h expected %h", tag, r, rd_bin[r*DW +: DW], exp_d[r]);
        end
        if (rd_oh[r*DW +: DW] !== exp_d[r]) begin
          fails++;
          $display("FAIL %s R8 port %0d: got %h expected %h", tag, r, rd_oh[r*DW +: DW], exp_d[r]);
        end
      end
    wr_en = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
    @(negedge clk);
    // R5: every port writes a distinct address each cycle
    for (int a = 0; a < DEPTH; a += NW) begin
      for (int w = 0; w < NW; w++) put(w, (a + w) % DEPTH, DW'(16'h1000 + a * 8 + w));
      for (int r = 0; r < NR; r++) look(r, (a + DEPTH - 1) % DEPTH);
      step("R5 fill");
    end
    // R1 R2 R6: all ports read back each address
    for (int a = 0; a < DEPTH; a++) begin
      for (int r = 0; r < NR; r++) look(r, a);
      step("R1 R2 R6 readback");
    end
    // R3: read on the same cycle as a write returns the old word
    for (int r = 0; r < NR; r++) look(r, 5);
    put(1, 5, 16'hBEEF);
    step("R3 old value");
    step("R1 new value");
    // R4: three writers in turn on one address
    put(0, 9, 16'hA000); for (int r = 0; r < NR; r++) look(r, 9); step("R4 w0");
    put(2, 9, 16'hA002); step("R4 w2");
    put(1, 9, 16'hA001); step("R4 w1");
    put(0, 9, 16'hA0F0); step("R4 w0 again");
    step("R4 final");
    // R9: held address with no writes
    look(0, 9); look(1, 3); look(2, 17);
    for (int k = 0; k < 4; k++) step("R9 hold");
    // R4 R5 R6: random traffic with distinct write addresses
    for (int k = 0; k < 3000; k++) begin
      int base;
      base = $urandom_range(DEPTH - 1);
      for (int w = 0; w < NW; w++)
        if ($urandom_range(3) != 0) put(w, (base + w) % DEPTH, DW'($urandom));
      for (int r = 0; r < NR; r++)
        look(r, ($urandom_range(2) == 0) ? (base + r) % DEPTH : $urandom_range(DEPTH - 1));
      step("R4 R5 R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule